// File: doc/BRIEF.md
# FIFO Occupancy Flag Generator with Read Rewind

This block keeps the write and read pointers of a first-in first-out buffer of `DEPTH` words and turns their distance into four active-low status flags: empty, full, half-full and a single "near an edge" flag. That last flag is low when the buffer is in its bottom eighth or its top eighth. The storage array sits outside the block and is addressed by the two pointer outputs. The serial assembly of words and the output drivers also sit outside the block.

Words enter through a valid/ready pair. A write is accepted on a rising edge only while `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the buffer is full, and an offered word that is not accepted is dropped, not held. Reads follow the same rule through `rd_valid`/`rd_ready`, and `rd_ready` is low exactly when the buffer is empty. A rewind request moves the read pointer back to location zero so the stored words can be read again. It leaves the write pointer where it is. A rewind is only meaningful while no more than `DEPTH` words have been written since reset. `DEPTH` must be a power of two and at least 16. Everything runs on one clock, and reset is active low and synchronous.

Top module: `fifo_occ_flags`

## Requirements
- R1: While `rst_n` is low at a rising edge, both addresses become 0, `empty_n` and `almost_n` go low, and `full_n` and `half_n` go high.
- R2: A write is accepted when `wr_valid` and `wr_ready` are both high at a rising edge. `wr_ready` equals `full_n`. An accepted write advances `wr_addr` by one, wrapping from `DEPTH-1` to 0.
- R3: A write offered while full is discarded. `wr_addr` and all flags stay unchanged.
- R4: A read is accepted when `rd_valid` and `rd_ready` are both high and `rewind` is low. `rd_ready` equals `empty_n`. An accepted read advances `rd_addr` by one, with wrap. A read offered while empty is ignored, and `rd_addr` and the flags stay unchanged.
- R5: A read and a write accepted in the same cycle leave the occupancy unchanged. When both are offered while empty, only the write takes effect. When both are offered while full, only the read takes effect.
- R6: `empty_n` is low exactly when the occupancy is 0. `full_n` is low exactly when the occupancy is `DEPTH`.
- R7: `almost_n` is low when the occupancy is below `DEPTH/8` or above `DEPTH-DEPTH/8`, and high otherwise. With `DEPTH`=2048 this means low for 0..255 and 1793..2048.
- R8: `half_n` is low exactly when the occupancy exceeds `DEPTH/2`. With `DEPTH`=2048 this means low for 1025..2048.
- R9: `rewind` high at a rising edge sets `rd_addr` to 0 and takes priority over a read in that cycle. The write side keeps its own behaviour. After the edge, the occupancy equals the number of words written since reset.
- R10: The flags, the ready outputs and the addresses take their new values in the cycle right after the rising edge that accepts a transfer. No further delay is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write can be accepted (not full) |
| rd_valid | input | 1 | Read requested |
| rd_ready | output | 1 | Read can be accepted (not empty) |
| rewind | input | 1 | Return read pointer to location zero |
| wr_addr | output | $clog2(DEPTH) | Storage location of the next write |
| rd_addr | output | $clog2(DEPTH) | Storage location of the next read |
| full_n | output | 1 | Low when occupancy is DEPTH |
| empty_n | output | 1 | Low when occupancy is 0 |
| half_n | output | 1 | Low when occupancy is above DEPTH/2 |
| almost_n | output | 1 | Low in the bottom or top eighth |

## Verification
The bench runs the main function under several patterns:
- A single-step ramp from empty to full. This passes every flag threshold one word at a time, so an off-by-one at 255/256, 1024/1025 or 1792/1793 shows up.
- A drain back to empty.
- Paired read-and-write cycles in the middle, at empty and at full. These separate the "occupancy unchanged" case from the two blocked-side cases.
- Strobes offered at the boundaries. These show whether blocked transfers really leave the pointers alone.
- A rewind with and without a competing read or write. This separates the read-only rewind from a full clear, and after it a complete re-read checks the rewound address sequence.

// File: rtl/fifoflag_pkg.sv
package fifoflag_pkg;
  typedef struct packed {
    logic full_n;
    logic empty_n;
    logic half_n;
    logic almost_n;
  } occ_flags_t;

  localparam occ_flags_t FLAGS_AT_RESET = '{full_n: 1'b1, empty_n: 1'b0,
                                            half_n: 1'b1, almost_n: 1'b0};
endpackage

// File: rtl/ffg_ptr.sv
module ffg_ptr #(
  parameter int AW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        rewind,
  output logic [AW:0] ptr
);
  // Pointer with one extra wrap bit so that full and empty differ.
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (rewind) ptr <= '0;
    else if (step)   ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/ffg_level.sv
module ffg_level
  import fifoflag_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [AW:0]  wptr,
  input  logic [AW:0]  rptr,
  output logic [AW:0]  occ,
  output occ_flags_t   flags
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] LOW_EDGE = (AW+1)'(DEPTH / 8);
  localparam logic [AW:0] TOP_EDGE = (AW+1)'(DEPTH - DEPTH / 8);
  localparam logic [AW:0] MID_LVL  = (AW+1)'(DEPTH / 2);

  assign occ = wptr - rptr;

  always_comb begin
    flags.empty_n  = (occ != '0);
    flags.full_n   = (occ != FULL_LVL);
    flags.half_n   = !(occ > MID_LVL);
    flags.almost_n = !((occ < LOW_EDGE) || (occ > TOP_EDGE));
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_LVL);                                                  // R6
  AST_NOT_BOTH_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flags.full_n && !flags.empty_n));                               // R6
  AST_EDGE_IMPLIES_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.full_n || !flags.empty_n) |-> !flags.almost_n);            // R7
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.full_n |-> !flags.half_n);                                  // R8
endmodule

// File: rtl/fifo_occ_flags.sv
module fifo_occ_flags
  import fifoflag_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic          rewind,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n,
  output logic          almost_n
);
  localparam int NPTR = 2;  // index 0: write side, 1: read side

  logic [AW:0] ptr_q   [NPTR];
  logic        ptr_adv [NPTR];
  logic        ptr_rw  [NPTR];
  logic [AW:0] occ;
  occ_flags_t  flags;
  logic        wr_fire, rd_fire;

  // Blocked sides fall out of the flags: a full buffer refuses writes,
  // an empty one refuses reads, and a rewind outranks a read.
  assign wr_fire = wr_valid & flags.full_n;
  assign rd_fire = rd_valid & flags.empty_n & ~rewind;

  assign ptr_adv[0] = wr_fire;
  assign ptr_rw[0]  = 1'b0;
  assign ptr_adv[1] = rd_fire;
  assign ptr_rw[1]  = rewind;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    ffg_ptr #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (ptr_adv[g]),
      .rewind (ptr_rw[g]),
      .ptr    (ptr_q[g])
    );
  end

  ffg_level #(.DEPTH(DEPTH), .AW(AW)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .wptr  (ptr_q[0]),
    .rptr  (ptr_q[1]),
    .occ   (occ),
    .flags (flags)
  );

  assign wr_addr  = ptr_q[0][AW-1:0];
  assign rd_addr  = ptr_q[1][AW-1:0];
  assign wr_ready = flags.full_n;
  assign rd_ready = flags.empty_n;
  assign full_n   = flags.full_n;
  assign empty_n  = flags.empty_n;
  assign half_n   = flags.half_n;
  assign almost_n = flags.almost_n;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (flags == FLAGS_AT_RESET && wr_addr == '0 && rd_addr == '0)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_valid && !rd_valid) |=> ($stable(wr_addr) && !full_n));    // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_valid && !rewind) |=> $stable(rd_addr));                 // R4
  AST_PAIR_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_valid && full_n && empty_n && !rewind) |=> $stable(occ)); // R5
  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> rd_addr == '0);                                               // R9
  AST_REWIND_KEEPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !wr_valid) |=> $stable(wr_addr));                             // R9
endmodule

// File: tb/tb_fifo_occ_flags.sv
module tb_fifo_occ_flags;
  localparam int N  = 2048;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n, wr_valid, rd_valid, rewind;
  logic wr_ready, rd_ready, full_n, empty_n, half_n, almost_n;
  logic [AW-1:0] wr_addr, rd_addr;

  always #5 clk = ~clk;

  fifo_occ_flags #(.DEPTH(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rewind(rewind),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .full_n(full_n),
    .empty_n(empty_n), .half_n(half_n), .almost_n(almost_n)
  );

  typedef struct {
    int    occ;
    int    wa;
    int    ra;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int m_wp = 0, m_rp = 0;   // model pointers modulo 2N

  function automatic int m_occ();
    return (m_wp - m_rp + 2 * N) % (2 * N);
  endfunction

  task automatic fail_line(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // Driver: one cycle of stimulus, expected state pushed for the monitor.
  task automatic drive(bit wv, bit rv, bit rt, string tag);
    exp_t e;
    int o;
    bit wacc, racc;
    @(negedge clk);
    wr_valid = wv; rd_valid = rv; rewind = rt;
    o    = m_occ();
    wacc = wv && (o < N);
    racc = rv && (o > 0) && !rt;
    if (wacc) m_wp = (m_wp + 1) % (2 * N);
    if (rt)   m_rp = 0;
    else if (racc) m_rp = (m_rp + 1) % (2 * N);
    e.occ = m_occ(); e.wa = m_wp % N; e.ra = m_rp % N; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares the state one edge after each driven cycle (R10).
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      bit ok;
      e = exp_q.pop_front();
      checks++;
      ok = 1'b1;
      if (empty_n !== (e.occ != 0)) begin ok = 0; fail_line({e.tag, "/R6"}, "empty_n", empty_n, e.occ != 0); end
      if (full_n !== (e.occ != N)) begin ok = 0; fail_line({e.tag, "/R6"}, "full_n", full_n, e.occ != N); end
      if (almost_n !== !((e.occ < N/8) || (e.occ > N - N/8))) begin
        ok = 0; fail_line({e.tag, "/R7"}, "almost_n", almost_n, !((e.occ < N/8) || (e.occ > N - N/8)));
      end
      if (half_n !== !(e.occ > N/2)) begin ok = 0; fail_line({e.tag, "/R8"}, "half_n", half_n, !(e.occ > N/2)); end
      if (wr_ready !== (e.occ != N)) begin ok = 0; fail_line({e.tag, "/R2"}, "wr_ready", wr_ready, e.occ != N); end
      if (rd_ready !== (e.occ != 0)) begin ok = 0; fail_line({e.tag, "/R4"}, "rd_ready", rd_ready, e.occ != 0); end
      if (int'(wr_addr) != e.wa) begin ok = 0; fail_line({e.tag, "/R2"}, "wr_addr", int'(wr_addr), e.wa); end
      if (int'(rd_addr) != e.ra) begin ok = 0; fail_line({e.tag, "/R4"}, "rd_addr", int'(rd_addr), e.ra); end
      if (!ok) $display("  (occupancy expected %0d)", e.occ);
    end
  end

  task automatic apply_reset();
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0; rewind = 1'b0;
    m_wp = 0; m_rp = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (!(empty_n === 1'b0 && almost_n === 1'b0 && full_n === 1'b1 && half_n === 1'b1
          && wr_addr == '0 && rd_addr == '0)) begin
      fail_line("R1", "flags{full,empty,half,almost}",
                int'({full_n, empty_n, half_n, almost_n}), 4'b1010);
    end
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0; rewind = 1'b0;
    apply_reset();                                            // R1

    repeat (3) drive(1, 0, 0, "R2");
    drive(0, 1, 0, "R4");
    drive(1, 1, 0, "R5");                                     // middle pair
    repeat (2) drive(0, 1, 0, "R4");
    repeat (2) drive(0, 1, 0, "R4");                          // ignored at empty
    drive(1, 1, 0, "R5");                                     // empty: write only
    drive(0, 1, 0, "R4");

    while (m_occ() < N) drive(1, 0, 0, "R7");                // ramp through thresholds
    repeat (2) drive(1, 0, 0, "R3");                          // discarded at full
    drive(1, 1, 0, "R5");                                     // full: read only
    drive(1, 0, 0, "R6");
    while (m_occ() > 0) drive(0, 1, 0, "R8");                // drain
    drive(0, 1, 0, "R4");
    while (m_occ() < 5) drive(1, 0, 0, "R2");                // wrap addresses
    drive(0, 0, 0, "R10");

    apply_reset();                                            // R1 mid-run
    repeat (300) drive(1, 0, 0, "R9");
    repeat (100) drive(0, 1, 0, "R9");
    drive(0, 1, 1, "R9");                                     // rewind beats read
    drive(1, 0, 1, "R9");                                     // rewind with write
    while (m_occ() > 0) drive(0, 1, 0, "R9");                // re-read all
    drive(0, 0, 0, "R9");

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule